// File: doc/BRIEF.md
# Multi-Bit ECC Error Location Corrector

This block applies the result of a hardware multi-bit ECC decode to one 512-byte sector held in a buffer. A decoder supplies three 32-bit location words and a status word. The status word carries a ready bit, a 4-bit error count, and the top byte of a packed field. Together these words hold up to eight 13-bit error bit positions.

After a start pulse, the block waits for the ready bit. It then captures the count and the packed positions. Each position has its two lowest bits inverted. Every position that lands inside the data area is used to flip one bit in the buffer, through a byte-wide read-modify-write port. When the work is finished, a one-cycle done pulse is raised. The pulse carries either the number of bits flipped or an uncorrectable flag.

The buffer port is a simple synchronous RAM interface. Read data appears one cycle after a read enable. A write takes effect at the clock edge where the write enable is high. Corrections are applied strictly one after another, so a repeated position flips the same bit back.

Top module: `ecc_loc_fixer`

## Requirements
- R1: After `start`, the block reads and writes nothing in the buffer and raises no `done` until status bit 15 (ready) is seen high. The count and the positions are captured in the cycle where ready is high.
- R2: The error count is status bits [13:10]. A count of zero ends the run with `done`, `fixed_cnt` = 0, `uncorrectable` = 0, and no buffer access.
- R3: A count above 8 ends the run with `done`, `uncorrectable` = 1, `fixed_cnt` = 0, and no buffer access.
- R4: The positions come from the 104-bit field {status[23:16], loc_w3, loc_w2, loc_w1}. Position k occupies bits [13k+12:13k], for k = 0..7. All other status bits are ignored.
- R5: Before use, bits 0 and 1 of every position are inverted.
- R6: Only positions 0 to count-1 are applied, in increasing order. A position that repeats flips its bit once per occurrence.
- R7: An adjusted position of 4096 or more does not touch the buffer and is not counted.
- R8: An adjusted position p flips bit p[2:0] of byte p[11:3]. The block asserts `mem_rd_en` for that byte. In the next cycle it asserts `mem_wr_en` to the same address with the read data XOR the bit mask.
- R9: `done` is a single-cycle pulse that comes after the last write. `fixed_cnt` equals the number of positions applied. Both `fixed_cnt` and `uncorrectable` hold their values until the next start.
- R10: While reset is asserted and after it is released, `done`, `mem_rd_en` and `mem_wr_en` are low and `fixed_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one sector correction; ignored while busy |
| status | input | 32 | Decoder status: ready [15], count [13:10], field top byte [23:16] |
| loc_w1 | input | 32 | Packed positions, field bits [31:0] |
| loc_w2 | input | 32 | Packed positions, field bits [63:32] |
| loc_w3 | input | 32 | Packed positions, field bits [95:64] |
| mem_addr | output | 9 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read request; data returns next cycle |
| mem_rdata | input | 8 | Buffer read data |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Corrected byte |
| done | output | 1 | One-cycle completion pulse |
| fixed_cnt | output | 4 | Number of bits flipped in the last run |
| uncorrectable | output | 1 | Last run had a count above 8 |

## Verification
Some properties are checked on every cycle. Every write must follow a read of the same address one cycle earlier. A read is always followed by a write. `done` lasts only one cycle. The reported count never exceeds eight, and it is zero whenever the uncorrectable flag is set.

Other behaviour only the bench scenarios can show. These include the exact bit layout of the packed field, the inversion of the low two bits, the skipping of positions outside the data area, and the cancelling effect of repeated positions. The bench shows these by sweeping every count from 0 to 15 over several position sets and comparing the whole buffer against an arithmetic model. It also holds ready low for a few cycles to show that the block waits.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SCAN,
        ST_PATCH,
        ST_DONE
    } fix_state_e;
endpackage

// File: rtl/ecc_loc_unpack.sv
module ecc_loc_unpack #(
    parameter int IDX_W   = 13,
    parameter int NUM_IDX = 8,
    parameter int INV_W   = 2
) (
    input  logic [NUM_IDX*IDX_W-1:0]         field,
    output logic [NUM_IDX-1:0][IDX_W-1:0]    idx_adj
);
    localparam logic [IDX_W-1:0] INV_MASK = IDX_W'((1 << INV_W) - 1);

    // each slot is a plain 13-bit slice; low bits arrive inverted
    for (genvar k = 0; k < NUM_IDX; k++) begin : g_slot
        assign idx_adj[k] = field[k*IDX_W +: IDX_W] ^ INV_MASK;
    end
endmodule

// File: rtl/ecc_bit_patch.sv
module ecc_bit_patch #(
    parameter int IDX_W      = 13,
    parameter int DATA_BYTES = 512,
    localparam int ADDR_W    = $clog2(DATA_BYTES)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        rd_byte,
    output logic              in_range,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        patched
);
    localparam int DATA_BITS = DATA_BYTES * 8;

    always_comb begin
        in_range  = 32'(idx) < DATA_BITS;
        byte_addr = idx[ADDR_W+2:3];
        patched   = rd_byte ^ (8'd1 << idx[2:0]);
    end
endmodule

// File: rtl/ecc_loc_fixer.sv
module ecc_loc_fixer
    import ecc_fix_pkg::*;
#(
    parameter int IDX_W      = 13,
    parameter int NUM_IDX    = 8,
    parameter int MAX_ERR    = 8,
    parameter int DATA_BYTES = 512,
    parameter int WORD_W     = 32,
    parameter int CNT_LSB    = 10,
    parameter int CNT_W      = 4,
    parameter int RDY_BIT    = 15,
    parameter int TOP_LSB    = 16,
    localparam int ADDR_W    = $clog2(DATA_BYTES),
    localparam int FIX_W     = $clog2(MAX_ERR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] status,
    input  logic [WORD_W-1:0] loc_w1,
    input  logic [WORD_W-1:0] loc_w2,
    input  logic [WORD_W-1:0] loc_w3,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata,
    output logic              done,
    output logic [FIX_W-1:0]  fixed_cnt,
    output logic              uncorrectable
);
    localparam int FIELD_W = NUM_IDX * IDX_W;
    localparam int TOP_W   = FIELD_W - 3 * WORD_W;
    localparam int SEL_W   = $clog2(NUM_IDX);

    typedef struct packed {
        fix_state_e         state;
        logic [FIELD_W-1:0] field;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   ptr;
        logic [FIX_W-1:0]   fixed;
        logic               unc;
    } fix_regs_t;

    fix_regs_t r_q, r_d;

    logic [NUM_IDX-1:0][IDX_W-1:0] idx_adj;
    logic [IDX_W-1:0]              cur_idx;
    logic                          cur_ok;
    logic [CNT_W-1:0]              new_cnt;
    logic [FIELD_W-1:0]            new_field;

    assign new_cnt   = status[CNT_LSB +: CNT_W];
    assign new_field = {status[TOP_LSB +: TOP_W], loc_w3, loc_w2, loc_w1};

    ecc_loc_unpack #(
        .IDX_W   (IDX_W),
        .NUM_IDX (NUM_IDX),
        .INV_W   (2)
    ) u_unpack (
        .field   (r_q.field),
        .idx_adj (idx_adj)
    );

    assign cur_idx = idx_adj[r_q.ptr[SEL_W-1:0]];

    ecc_bit_patch #(
        .IDX_W      (IDX_W),
        .DATA_BYTES (DATA_BYTES)
    ) u_patch (
        .idx       (cur_idx),
        .rd_byte   (mem_rdata),
        .in_range  (cur_ok),
        .byte_addr (mem_addr),
        .patched   (mem_wdata)
    );

    always_comb begin
        r_d       = r_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_WAIT;
                    r_d.fixed = '0;
                    r_d.unc   = 1'b0;
                end
            end
            ST_WAIT: begin
                if (status[RDY_BIT]) begin
                    r_d.field = new_field;
                    r_d.cnt   = new_cnt;
                    r_d.ptr   = '0;
                    if (new_cnt == '0) begin
                        r_d.state = ST_DONE;
                    end else if (new_cnt > CNT_W'(MAX_ERR)) begin
                        r_d.unc   = 1'b1;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (r_q.ptr == r_q.cnt) begin
                    r_d.state = ST_DONE;
                end else if (!cur_ok) begin
                    r_d.ptr = r_q.ptr + 1'b1;
                end else begin
                    mem_rd_en = 1'b1;
                    r_d.state = ST_PATCH;
                end
            end
            ST_PATCH: begin
                mem_wr_en = 1'b1;
                r_d.ptr   = r_q.ptr + 1'b1;
                r_d.fixed = r_q.fixed + 1'b1;
                r_d.state = ST_SCAN;
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.field <= '0;
            r_q.cnt   <= '0;
            r_q.ptr   <= '0;
            r_q.fixed <= '0;
            r_q.unc   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done          = (r_q.state == ST_DONE);
    assign fixed_cnt     = r_q.fixed;
    assign uncorrectable = r_q.unc;

    // a write always completes the read issued one cycle earlier
    p_wr_follows_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

    p_rd_then_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_cnt <= FIX_W'(MAX_ERR));

    p_unc_no_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (fixed_cnt == '0));
endmodule

// File: tb/tb_ecc_loc_fixer.sv
module tb_ecc_loc_fixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] status = '0;
    logic [31:0] loc_w1 = '0, loc_w2 = '0, loc_w3 = '0;
    logic [8:0]  mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        done;
    logic [3:0]  fixed_cnt;
    logic        uncorrectable;

    int checks = 0;
    int errors = 0;
    int activity = 0;

    logic [7:0] mem [512];
    logic [7:0] expm [512];
    logic [7:0] rd_q = '0;

    always #10 clk = ~clk;

    ecc_loc_fixer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .status(status),
        .loc_w1(loc_w1), .loc_w2(loc_w2), .loc_w3(loc_w3),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done),
        .fixed_cnt(fixed_cnt), .uncorrectable(uncorrectable)
    );

    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (mem_rd_en) rd_q <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (rst_n && (mem_rd_en || mem_wr_en)) activity <= activity + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] gen_raw(input int seed, input int k);
        logic [12:0] special [8];
        special = '{13'd0, 13'd1, 13'd2, 13'd3, 13'd4092, 13'd4095, 13'd4096, 13'd4099};
        case (seed)
            0: return special[k];
            1: return 13'd4097 + 13'(k * 300);
            2: return 13'd1234;
            default: return 13'((seed * 1237 + k * 2971 + k * k * 53) % 8192);
        endcase
    endfunction

    task automatic run_case(input int cnt, input int seed, input bit late);
        logic [103:0] pk;
        logic [12:0]  raw [8];
        int n_exp, a, act0, waited;
        bit seen;
        for (int k = 0; k < 8; k++) begin
            raw[k] = gen_raw(seed, k);
            pk[13*k +: 13] = raw[k];
        end
        for (int i = 0; i < 512; i++) begin
            mem[i]  = 8'((i * 37 + seed * 11 + cnt) & 255);
            expm[i] = mem[i];
        end
        n_exp = 0;
        if (cnt >= 1 && cnt <= 8) begin
            for (int k = 0; k < cnt; k++) begin
                a = int'(raw[k] ^ 13'd3);
                if (a < 4096) begin
                    expm[a >> 3] = expm[a >> 3] ^ (8'd1 << (a & 7));
                    n_exp++;
                end
            end
        end
        loc_w1 = pk[31:0];
        loc_w2 = pk[63:32];
        loc_w3 = pk[95:64];
        // junk in unused status bits checks they are ignored (R4)
        status = {8'hA5, pk[103:96], 1'b0, 1'b1, 4'(cnt), 10'h2AB};
        start  = 1'b1;
        act0   = activity;
        @(negedge clk);
        start = 1'b0;
        if (late) begin
            seen = 1'b0;
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            check(!seen && activity == act0, "R1 wait for ready", activity - act0, 0);
        end
        status[15] = 1'b1;
        seen = 1'b0;
        waited = 0;
        while (!seen && waited < 100) begin
            @(negedge clk);
            waited++;
            if (done) seen = 1'b1;
        end
        check(seen, "R9 done raised", int'(seen), 1);
        check(int'(fixed_cnt) == n_exp, "R6 R7 R9 corrected count", fixed_cnt, n_exp);
        check(uncorrectable == (cnt > 8), "R3 uncorrectable flag", uncorrectable, int'(cnt > 8));
        if (cnt == 0 || cnt > 8)
            check(activity == act0, "R2 R3 no buffer access", activity - act0, 0);
        status[15] = 1'b0;
        @(negedge clk);
        check(!done, "R9 done is one cycle", done, 0);
        check(int'(fixed_cnt) == n_exp, "R9 count held", fixed_cnt, n_exp);
        a = -1;
        for (int i = 0; i < 512; i++)
            if (a < 0 && mem[i] !== expm[i]) a = i;
        check(a < 0, "R4 R5 R8 buffer contents (first bad byte)", a,
              a < 0 ? -1 : int'(expm[a]));
    endtask

    initial begin
        #5_000_000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !mem_rd_en && !mem_wr_en && fixed_cnt == 0,
              "R10 reset state", int'({done, mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !mem_rd_en && !mem_wr_en && fixed_cnt == 0,
              "R10 idle after reset", int'({done, mem_rd_en, mem_wr_en}), 0);
        for (int seed = 0; seed < 6; seed++)
            for (int cnt = 0; cnt < 16; cnt++)
                run_case(cnt, seed, cnt[0]);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule